// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one DMA channel that moves a run of bytes from a 64-bit source address to a 64-bit destination address. Software sets it up through a small 32-bit register port with eight word slots. A control word claims the channel, starts it and reports completion. A configuration word picks the read and write transfer sizes. Three 64-bit registers hold the byte count, the destination and the source. Software can reach each of them as two separate 32-bit words.

Once started, the channel takes private working copies of count, source and destination. It then loops one beat at a time: a read request at the source, a wait for the returned data, then a write request at the destination. After each beat both addresses move forward by one transfer unit and the count drops by the bytes moved. When the count reaches zero, the run bit drops and a done flag rises. The memory master is a single request channel with a valid/ready handshake. Read data comes back on its own valid strobe, and writes get no response.

Top module: `memcpy_dma`

## Requirements
- R1: After reset every register reads zero and no memory request is issued.
- R2: Word slots 2/3, 4/5 and 6/7 hold the low/high halves of count, destination and source. Each half is written and read back on its own. Slot 1 keeps the write-size field in bits 31:28 and the read-size field in bits 27:24, and its other bits read as zero.
- R3: Slot 0 is control, with claim in bit 0, run in bit 1 and done in bit 30. Writing bit 0 = 0 releases the channel and clears done. A new start (bits 0 and 1 both set) also clears done.
- R4: A control write with run set but claim clear leaves run at 0 and causes no memory access.
- R5: A start loads working copies of the programmed values. Each beat is one read at the source followed by one write at the destination, so the destination receives the source bytes and nothing is ever written to the source.
- R6: The unit is 2^min(read size, write size, 3) bytes, and the last beat is cut to the bytes left. Strobes cover the beat's bytes starting at lane address[2:0]. Read data is moved from the source lane offset to the destination lane offset.
- R7: On completion run clears, claim stays set and done sets, so control reads 0x40000001.
- R8: A start with a byte count of zero sets done with no memory request.
- R9: While run is set, writes to configuration, count, address and control slots are ignored.
- R10: A request not yet accepted keeps valid, address and direction unchanged until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word_addr | input | 3 | Register word slot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the addressed slot (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 64 | Byte address of request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_wdata | output | 64 | Write data, lane-aligned |
| mem_req_strb | output | 8 | Byte lane enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |

## Verification
A bad sequencing state shows up at the control word within a few cycles. Run would stay stuck high past the expected number of handshakes, or done would appear with the wrong count of reads and writes at the memory port. A wrong working count or lane offset shows up only in memory: destination bytes outside the beat get overwritten, or bytes inside it come out shifted. The bench therefore compares every destination byte, plus the two bytes just past the end, after each copy. Ignored writes during a stalled transfer are checked by reading the registers back after completion and by counting the beats actually issued.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_CFG  = 1;
    localparam int CTRL_CLAIM_BIT = 0;
    localparam int CTRL_RUN_BIT   = 1;
    localparam int CTRL_DONE_BIT  = 30;
    localparam int NUM_WIDE = 3;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RD,
        ENG_WAIT,
        ENG_WR,
        ENG_FIN
    } eng_st_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int CW = 64,
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [2:0]    slot_i,
    input  logic [31:0]   wdata_i,
    output logic [31:0]   rdata_o,
    input  logic          fin_i,
    output logic          run_o,
    output logic          start_o,
    output logic [CW-1:0] cnt_o,
    output logic [AW-1:0] dst_o,
    output logic [AW-1:0] src_o,
    output logic [3:0]    rsz_o,
    output logic [3:0]    wsz_o
);
    typedef struct packed {
        logic       claim;
        logic       run;
        logic       done;
        logic [3:0] wsz;
        logic [3:0] rsz;
        logic [NUM_WIDE-1:0][63:0] wide;
    } regs_t;

    regs_t q, d;
    logic [1:0] wide_sel;

    assign wide_sel = slot_i[2:1];

    always_comb begin
        d = q;
        start_o = 1'b0;
        if (we_i && !q.run) begin
            if (wide_sel == 2'd0) begin
                if (slot_i[0] == 1'b0) begin
                    d.claim = wdata_i[CTRL_CLAIM_BIT];
                    if (!wdata_i[CTRL_CLAIM_BIT]) begin
                        d.done = 1'b0;
                    end else if (wdata_i[CTRL_RUN_BIT]) begin
                        d.run   = 1'b1;
                        d.done  = 1'b0;
                        start_o = 1'b1;
                    end
                end else begin
                    d.wsz = wdata_i[31:28];
                    d.rsz = wdata_i[27:24];
                end
            end else begin
                for (int k = 0; k < NUM_WIDE; k++) begin
                    if (wide_sel == 2'(k + 1)) begin
                        d.wide[k][slot_i[0]*32 +: 32] = wdata_i;
                    end
                end
            end
        end
        if (fin_i) begin
            d.run  = 1'b0;
            d.done = 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (wide_sel == 2'd0) begin
            if (slot_i[0] == 1'b0) begin
                rdata_o[CTRL_CLAIM_BIT] = q.claim;
                rdata_o[CTRL_RUN_BIT]   = q.run;
                rdata_o[CTRL_DONE_BIT]  = q.done;
            end else begin
                rdata_o[31:28] = q.wsz;
                rdata_o[27:24] = q.rsz;
            end
        end else begin
            for (int k = 0; k < NUM_WIDE; k++) begin
                if (wide_sel == 2'(k + 1)) begin
                    rdata_o = q.wide[k][slot_i[0]*32 +: 32];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run_o = q.run;
    assign cnt_o = CW'(q.wide[0]);
    assign dst_o = AW'(q.wide[1]);
    assign src_o = AW'(q.wide[2]);
    assign rsz_o = q.rsz;
    assign wsz_o = q.wsz;

    // R4
    run_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> q.claim);
    // R7
    run_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.run && q.done));
    // R7
    fin_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> (q.done && !q.run && q.claim));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int CW = 64,
    parameter int AW = 64,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [3:0]    rsz_i,
    input  logic [3:0]    wsz_i,
    output logic          fin_o,
    output logic          req_valid_o,
    input  logic          req_ready_i,
    output logic [AW-1:0] req_addr_o,
    output logic          req_we_o,
    output logic [DW-1:0] req_wdata_o,
    output logic [DW/8-1:0] req_strb_o,
    input  logic          rsp_valid_i,
    input  logic [DW-1:0] rsp_data_i
);
    localparam int BW    = DW / 8;
    localparam int OFF_W = $clog2(BW);
    localparam int SZW   = $clog2(OFF_W + 1);

    typedef struct packed {
        eng_st_e       st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [SZW-1:0] sz;
        logic [DW-1:0] data;
    } eng_t;

    eng_t q, d;
    logic [OFF_W-1:0] off_s, off_d;
    logic [OFF_W:0]   beat;
    logic [CW-1:0]    unit_c;
    logic [AW-1:0]    unit_a;

    function automatic logic [SZW-1:0] pick_size(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] m;
        m = (a < b) ? a : b;
        if (m > 4'(OFF_W)) m = 4'(OFF_W);
        return SZW'(m);
    endfunction

    function automatic logic [BW-1:0] lane_mask(input logic [OFF_W-1:0] off, input logic [OFF_W:0] n);
        logic [BW-1:0] m;
        for (int i = 0; i < BW; i++) begin
            m[i] = (i >= int'(off)) && (i < int'(off) + int'(n));
        end
        return m;
    endfunction

    always_comb begin
        d = q;
        fin_o = 1'b0;
        req_valid_o = 1'b0;
        req_we_o = 1'b0;
        req_addr_o = q.src;
        req_strb_o = '0;
        off_s = q.src[OFF_W-1:0];
        off_d = q.dst[OFF_W-1:0];
        unit_c = CW'(1) << q.sz;
        unit_a = AW'(1) << q.sz;
        beat = (q.cnt < unit_c) ? q.cnt[OFF_W:0] : unit_c[OFF_W:0];
        req_wdata_o = q.data << {off_d, 3'b000};
        case (q.st)
            ENG_IDLE: begin
                if (start_i) begin
                    d.cnt = cnt_i;
                    d.src = src_i;
                    d.dst = dst_i;
                    d.sz  = pick_size(rsz_i, wsz_i);
                    d.st  = (cnt_i == '0) ? ENG_FIN : ENG_RD;
                end
            end
            ENG_RD: begin
                req_valid_o = 1'b1;
                req_strb_o  = lane_mask(off_s, beat);
                if (req_ready_i) d.st = ENG_WAIT;
            end
            ENG_WAIT: begin
                if (rsp_valid_i) begin
                    d.data = rsp_data_i >> {off_s, 3'b000};
                    d.st   = ENG_WR;
                end
            end
            ENG_WR: begin
                req_valid_o = 1'b1;
                req_we_o    = 1'b1;
                req_addr_o  = q.dst;
                req_strb_o  = lane_mask(off_d, beat);
                if (req_ready_i) begin
                    d.cnt = q.cnt - CW'(beat);
                    d.src = q.src + unit_a;
                    d.dst = q.dst + unit_a;
                    d.st  = (q.cnt == CW'(beat)) ? ENG_FIN : ENG_RD;
                end
            end
            ENG_FIN: begin
                fin_o = 1'b1;
                d.st  = ENG_IDLE;
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_we_o)));
    // R6
    strb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_strb_o != '0));
endmodule

// File: rtl/memcpy_dma.sv
module memcpy_dma #(
    parameter int CW = 64,
    parameter int AW = 64,
    parameter int DW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_word_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [AW-1:0]   mem_req_addr,
    output logic            mem_req_we,
    output logic [DW-1:0]   mem_req_wdata,
    output logic [DW/8-1:0] mem_req_strb,
    input  logic            mem_rsp_valid,
    input  logic [DW-1:0]   mem_rsp_data
);
    logic          fin, run, start;
    logic [CW-1:0] cnt;
    logic [AW-1:0] src, dst;
    logic [3:0]    rsz, wsz;

    dma_regs #(.CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .slot_i(reg_word_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .fin_i(fin), .run_o(run),
        .start_o(start), .cnt_o(cnt), .dst_o(dst), .src_o(src),
        .rsz_o(rsz), .wsz_o(wsz)
    );

    dma_engine #(.CW(CW), .AW(AW), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cnt_i(cnt), .src_i(src),
        .dst_i(dst), .rsz_i(rsz), .wsz_i(wsz), .fin_o(fin),
        .req_valid_o(mem_req_valid), .req_ready_i(mem_req_ready),
        .req_addr_o(mem_req_addr), .req_we_o(mem_req_we),
        .req_wdata_o(mem_req_wdata), .req_strb_o(mem_req_strb),
        .rsp_valid_i(mem_rsp_valid), .rsp_data_i(mem_rsp_data)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mem_req_valid);
    // R7
    fin_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> run);
endmodule

// File: tb/tb_memcpy_dma.sv
module tb_memcpy_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_word_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_req_we;
    logic [63:0] mem_req_wdata;
    logic [7:0]  mem_req_strb;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    memcpy_dma dut (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    int n_rd = 0, n_wr = 0, src_wr = 0, hold_err = 0, cyc = 0;
    logic [7:0] last_wstrb = '0, first_rstrb = '0;
    logic stall = 1'b0, finished = 1'b0;
    logic [63:0] mem [0:1023];
    localparam logic [63:0] DST = 64'h2_8000_0000;
    localparam logic [63:0] SRC = 64'h2_8000_1000;

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] getb(input logic [63:0] a);
        return mem[a[12:3]][8*a[2:0] +: 8];
    endfunction

    // memory responder, drives inputs away from the active edge
    initial begin
        logic pend = 1'b0, pv = 1'b0;
        logic [63:0] pdata = '0, paddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = pend;
            mem_rsp_data  = pdata;
            pend = 1'b0;
            cyc++;
            mem_req_ready = stall ? 1'b0 : ((cyc % 3) != 1);
            if (pv && !(mem_req_valid && mem_req_addr == paddr)) hold_err++;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    n_wr++;
                    last_wstrb = mem_req_strb;
                    if (mem_req_addr >= SRC && mem_req_addr < SRC + 64'h1000) src_wr++;
                    for (int b = 0; b < 8; b++)
                        if (mem_req_strb[b]) mem[mem_req_addr[12:3]][8*b +: 8] = mem_req_wdata[8*b +: 8];
                end else begin
                    if (n_rd == 0) first_rstrb = mem_req_strb;
                    n_rd++;
                    pend = 1'b1;
                    pdata = mem[mem_req_addr[12:3]];
                end
            end
            pv = mem_req_valid && !mem_req_ready;
            paddr = mem_req_addr;
        end
    end

    task automatic wr(input int slot, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_word_addr = 3'(slot); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int slot, output logic [31:0] v);
        @(negedge clk);
        reg_word_addr = 3'(slot);
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(0, v);
            if (!v[1]) break;
        end
    endtask

    task automatic clear_stats();
        n_rd = 0; n_wr = 0; src_wr = 0; hold_err = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 8; s++) begin
            rd(s, v);
            check(v == 0, "R1 reg after reset", 64'(v), 0);
        end
        check(!mem_req_valid, "R1 no request", 64'(mem_req_valid), 0);
    endtask

    task automatic t_halves();
        logic [31:0] v;
        for (int s = 2; s < 8; s++) wr(s, 32'hA500_0000 + 32'(s));
        for (int s = 2; s < 8; s++) begin
            rd(s, v);
            check(v == 32'hA500_0000 + 32'(s), "R2 half readback", 64'(v), 64'(32'hA500_0000 + 32'(s)));
        end
        wr(1, 32'h32FF_FFFF);
        rd(1, v);
        check(v == 32'h3200_0000, "R2 cfg fields only", 64'(v), 64'h3200_0000);
    endtask

    task automatic t_no_claim();
        logic [31:0] v;
        clear_stats();
        wr(0, 32'h2);
        rd(0, v);
        check(v == 0, "R4 run without claim", 64'(v), 0);
        repeat (10) @(negedge clk);
        check(n_rd + n_wr == 0, "R4 no access", 64'(n_rd + n_wr), 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        clear_stats();
        mem[0] = 64'h0000_0000_8765_4321;
        mem[10'h200] = 64'h0000_0000_1234_5678;
        wr(0, 1); wr(1, 32'h2200_0000);
        wr(2, 4); wr(3, 0);
        wr(4, DST[31:0]); wr(5, DST[63:32]);
        wr(6, SRC[31:0]); wr(7, SRC[63:32]);
        wr(0, 3);
        wait_idle();
        rd(0, v);
        check(v == 32'h4000_0001, "R7 ctrl after done", 64'(v), 64'h4000_0001);
        check(mem[0][31:0] == 32'h1234_5678, "R5 dst copied", 64'(mem[0][31:0]), 64'h1234_5678);
        check(mem[10'h200] == 64'h1234_5678, "R5 src unchanged", mem[10'h200], 64'h1234_5678);
        check(n_rd == 1 && n_wr == 1 && src_wr == 0, "R5 one read one write", 64'(n_rd*16 + n_wr), 64'h11);
        check(last_wstrb == 8'h0F, "R6 write strobe", 64'(last_wstrb), 64'h0F);
        check(hold_err == 0, "R10 request held", 64'(hold_err), 0);
    endtask

    task automatic t_lanes();
        logic [31:0] v;
        int bad = 0;
        clear_stats();
        for (int w = 0; w < 3; w++) mem[10'h200 + w] = 64'h0807_0605_0403_0201 + 64'h1010_1010_1010_1010 * w;
        mem[10'h20] = {8{8'hAA}};
        mem[10'h21] = {8{8'hAA}};
        wr(1, 32'h3200_0000);
        wr(2, 10);
        wr(4, DST[31:0] + 32'h100);
        wr(6, SRC[31:0] + 32'h4);
        wr(0, 3);
        wait_idle();
        for (int i = 0; i < 10; i++)
            if (getb(DST + 64'h100 + 64'(i)) != getb(SRC + 64'h4 + 64'(i))) bad++;
        check(bad == 0, "R6 lane-shifted copy", 64'(bad), 0);
        check(getb(DST + 64'h10A) == 8'hAA && getb(DST + 64'h10B) == 8'hAA, "R6 bytes past end untouched",
              64'(getb(DST + 64'h10A)), 64'hAA);
        check(n_rd == 3 && n_wr == 3, "R6 three beats", 64'(n_rd*16 + n_wr), 64'h33);
        check(first_rstrb == 8'hF0, "R6 read strobe at offset", 64'(first_rstrb), 64'hF0);
        check(last_wstrb == 8'h03, "R6 short last beat", 64'(last_wstrb), 64'h03);
        rd(0, v);
        check(v == 32'h4000_0001, "R7 done after multi-beat", 64'(v), 64'h4000_0001);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        clear_stats();
        wr(1, 32'h2200_0000); wr(2, 4);
        wr(4, DST[31:0]); wr(6, SRC[31:0]);
        stall = 1'b1;
        wr(0, 3);
        wr(2, 32'h99); wr(6, 32'h0); wr(1, 32'h0); wr(0, 0);
        rd(0, v);
        check(v == 32'h3, "R9 ctrl ignored while run", 64'(v), 3);
        repeat (4) @(negedge clk);
        stall = 1'b0;
        wait_idle();
        rd(2, v); check(v == 4, "R9 count kept", 64'(v), 4);
        rd(6, v); check(v == SRC[31:0], "R9 src kept", 64'(v), 64'(SRC[31:0]));
        rd(1, v); check(v == 32'h2200_0000, "R9 cfg kept", 64'(v), 64'h2200_0000);
        check(n_wr == 1, "R9 copy used old count", 64'(n_wr), 1);
        check(hold_err == 0, "R10 held through stall", 64'(hold_err), 0);
    endtask

    task automatic t_release();
        logic [31:0] v;
        wr(0, 0);
        rd(0, v);
        check(v == 0, "R3 release clears done", 64'(v), 0);
        wr(0, 1);
        rd(0, v);
        check(v == 1, "R3 claim", 64'(v), 1);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        clear_stats();
        wr(2, 0); wr(3, 0);
        wr(0, 3);
        wait_idle();
        rd(0, v);
        check(v == 32'h4000_0001, "R8 zero count done", 64'(v), 64'h4000_0001);
        check(n_rd + n_wr == 0, "R8 no access", 64'(n_rd + n_wr), 0);
        wr(2, 4);
        stall = 1'b1;
        wr(0, 3);
        rd(0, v);
        check(v == 32'h3, "R3 new start clears done", 64'(v), 3);
        stall = 1'b0;
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halves();
        t_no_claim();
        t_basic();
        t_lanes();
        t_locked();
        t_release();
        t_zero();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 64'(1), 64'(0));
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule